// File: doc/BRIEF.md
# Subscriber Line State Control Latch and Decoder

This block sits between a line-card controller and the analog front end of one subscriber line. The controller presents a six-bit command on a parallel bus and pulses an active-low select strobe. On the strobe's rising edge the block stores the command. It then decodes the stored command into the enables for six line switches, two feedback switches, the power-down controls of the tip and ring amplifiers, a polarity flag, a low-current-limit flag and the source selection for the active-low detect output.

The low four command bits choose one of sixteen line states. Bit 4 closes the test-in switches and bit 5 drives the relay output. Each of these two bits acts on its own, whatever the line state. The strobe, the command bits and the three status inputs (switchhook detector, ring-trip detector, thermal fault) are asynchronous to the block clock. Each passes through a synchronizer before use. A thermal fault always pulls the detect output low. The one unused state code puts the line into high impedance and raises a sticky error flag.

Top module: `line_ctrl_top`

## Requirements
- R1: The command is stored only when the synchronized select input goes from low to high. Command changes while select stays high, while it stays low, or when it falls, leave every output unchanged.
- R2: Codes 1111, 0111, 1010, 0101, 1001 and 0001 (bits 3..0) close SW2 and SW4 (sw_o bits 1 and 3) and both feedback switches (fb_sw_o bit 0 = SW2A, bit 1 = SW4A). They power both amplifiers and keep SW1 and SW5 (sw_o bits 0 and 4) open. low_ilim_o is 1 only for 1001 and 0001. rev_pol_o is 1 only for 0111, 0110, 0100 and 0001.
- R3: Tip-open codes 1110 and 0110 open SW2 and SW2A and power down the tip amplifier. Ring path stays closed. Code 1101 gives the same result with SW1 closed as well.
- R4: Ring-open codes 1100 and 0100 open SW4 and SW4A and power down the ring amplifier. Tip path stays closed.
- R5: Ringing codes 1011 and 0011 close SW1 and SW5, open SW2, SW4 and both feedback switches, and power down both amplifiers. They set det_sel_o, so that det_n_o is low exactly when the ring-trip input is high.
- R6: High-impedance codes 1000 and 0000 open SW1, SW2, SW4, SW5 and both feedback switches and power down both amplifiers. det_n_o is held high unless a thermal fault is present.
- R7: Command bit 4 = 0 closes SW3 and SW6 (sw_o bits 2 and 5), and bit 5 = 0 drives relay_n_o low. Both act in every line state.
- R8: An active thermal-fault input drives det_n_o low in every state.
- R9: Code 0010 gives the high-impedance configuration and sets bad_code_o. The flag stays set until reset.
- R10: Reset loads the parameter RST_WORD (default all zeros) as the stored command. With the default, the outputs are high impedance, test-in closed, relay on, bad_code_o clear and det_n_o high.
- R11: In the talk states of R2 and the states of R3 and R4, det_n_o is low exactly when the switchhook input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Active-low select strobe; rising edge stores the command |
| cmd_i | input | 6 | Command word: bits 3..0 line state, bit 4 test-in (0 = closed), bit 5 relay (0 = on) |
| hook_i | input | 1 | Switchhook detector, high = off-hook |
| trip_i | input | 1 | Ring-trip detector, high = tripped |
| therm_i | input | 1 | Thermal fault, high = fault |
| sw_o | output | 6 | Line switch enables, bit n-1 closes SWn |
| fb_sw_o | output | 2 | Feedback switch enables, bit 0 SW2A, bit 1 SW4A |
| tip_pd_o | output | 1 | Tip amplifier power-down |
| ring_pd_o | output | 1 | Ring amplifier power-down |
| rev_pol_o | output | 1 | Reverse battery polarity |
| low_ilim_o | output | 1 | Reduced current limit |
| det_sel_o | output | 1 | Detect source: 1 = ring-trip, 0 = switchhook |
| det_n_o | output | 1 | Active-low detect output |
| relay_n_o | output | 1 | Active-low relay driver |
| bad_code_o | output | 1 | Sticky flag for the unassigned state code |

## Verification
After select rises at the pin, its synchronizer takes two clock edges. The command is stored on the third edge and the decoded outputs register on the fourth. The bench therefore changes inputs on a falling edge, waits four rising edges and samples on the next falling edge. A change on a detector or thermal input takes two synchronizer edges plus the output register, so the bench samples det_n_o after three rising edges. For the hold tests it waits well past four edges and then confirms that nothing has moved.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int CMD_W = 6;
  localparam int NSW   = 6;
  localparam int NFB   = 2;

  typedef struct packed {
    logic [NSW-1:0] sw;
    logic [NFB-1:0] fb;
    logic           tip_pd;
    logic           ring_pd;
    logic           rev;
    logic           low_ilim;
    logic           det_trip;
    logic           hiz;
    logic           bad;
  } lc_ctrl_t;

  // Maps a stored command to the line control set (relay bit handled apart).
  function automatic lc_ctrl_t lc_decode(input logic [CMD_W-1:0] w);
    lc_ctrl_t c;
    c = '0;
    unique case (w[3:0])
      4'b1111, 4'b0111, 4'b1010, 4'b0101, 4'b1001, 4'b0001: begin
        c.sw[1] = 1'b1; c.sw[3] = 1'b1; c.fb = 2'b11;
      end
      4'b1110, 4'b0110: begin
        c.sw[3] = 1'b1; c.fb = 2'b10; c.tip_pd = 1'b1;
      end
      4'b1101: begin
        c.sw[0] = 1'b1; c.sw[3] = 1'b1; c.fb = 2'b10; c.tip_pd = 1'b1;
      end
      4'b1100, 4'b0100: begin
        c.sw[1] = 1'b1; c.fb = 2'b01; c.ring_pd = 1'b1;
      end
      4'b1011, 4'b0011: begin
        c.sw[0] = 1'b1; c.sw[4] = 1'b1;
        c.tip_pd = 1'b1; c.ring_pd = 1'b1; c.det_trip = 1'b1;
      end
      4'b0010: begin
        c.tip_pd = 1'b1; c.ring_pd = 1'b1; c.hiz = 1'b1; c.bad = 1'b1;
      end
      default: begin
        c.tip_pd = 1'b1; c.ring_pd = 1'b1; c.hiz = 1'b1;
      end
    endcase
    c.rev      = (w[3:0] == 4'b0111) || (w[3:0] == 4'b0110) ||
                 (w[3:0] == 4'b0100) || (w[3:0] == 4'b0001);
    c.low_ilim = (w[2:0] == 3'b001);
    if (!w[4]) begin
      c.sw[2] = 1'b1;
      c.sw[5] = 1'b1;
    end
    return c;
  endfunction
endpackage

// File: rtl/lc_sync.sv
module lc_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/lc_cmd_latch.sv
module lc_cmd_latch #(
  parameter int          W        = 6,
  parameter logic [W-1:0] RST_WORD = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_s_i,
  input  logic [W-1:0] data_s_i,
  output logic         cap_en_o,
  output logic [W-1:0] word_o
);
  logic sel_prev;

  assign cap_en_o = sel_s_i & ~sel_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_prev <= 1'b1;
      word_o   <= RST_WORD;
    end else begin
      sel_prev <= sel_s_i;
      if (cap_en_o) word_o <= data_s_i;
    end
  end
endmodule

// File: rtl/lc_line_decode.sv
module lc_line_decode
  import lc_pkg::*;
(
  input  logic [CMD_W-1:0] word_i,
  input  logic             hook_s_i,
  input  logic             trip_s_i,
  input  logic             therm_s_i,
  output lc_ctrl_t         ctrl_o,
  output logic             det_n_o
);
  always_comb begin
    ctrl_o = lc_decode(word_i);
    if (therm_s_i)          det_n_o = 1'b0;
    else if (ctrl_o.hiz)    det_n_o = 1'b1;
    else if (ctrl_o.det_trip) det_n_o = ~trip_s_i;
    else                    det_n_o = ~hook_s_i;
  end
endmodule

// File: rtl/line_ctrl_top.sv
module line_ctrl_top
  import lc_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter logic [CMD_W-1:0] RST_WORD   = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             hook_i,
  input  logic             trip_i,
  input  logic             therm_i,
  output logic [NSW-1:0]   sw_o,
  output logic [NFB-1:0]   fb_sw_o,
  output logic             tip_pd_o,
  output logic             ring_pd_o,
  output logic             rev_pol_o,
  output logic             low_ilim_o,
  output logic             det_sel_o,
  output logic             det_n_o,
  output logic             relay_n_o,
  output logic             bad_code_o
);
  localparam int       BUS_W    = CMD_W + 1;
  localparam lc_ctrl_t RST_CTRL = lc_decode(RST_WORD);

  logic [BUS_W-1:0] bus_s;
  logic [2:0]       stat_s;
  logic             sel_s, hook_s, trip_s, therm_s;
  logic [CMD_W-1:0] cmd_s, word;
  logic             cap_en;
  lc_ctrl_t         ctrl_d, ctrl_q;
  logic             det_d, det_q, relay_q, bad_q;

  lc_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL({1'b1, RST_WORD})) u_bus_sync (
    .clk(clk), .rst(rst), .d_i({sel_n_i, cmd_i}), .q_o(bus_s)
  );

  lc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_stat_sync (
    .clk(clk), .rst(rst), .d_i({therm_i, trip_i, hook_i}), .q_o(stat_s)
  );

  assign sel_s   = bus_s[BUS_W-1];
  assign cmd_s   = bus_s[CMD_W-1:0];
  assign hook_s  = stat_s[0];
  assign trip_s  = stat_s[1];
  assign therm_s = stat_s[2];

  lc_cmd_latch #(.W(CMD_W), .RST_WORD(RST_WORD)) u_latch (
    .clk(clk), .rst(rst), .sel_s_i(sel_s), .data_s_i(cmd_s),
    .cap_en_o(cap_en), .word_o(word)
  );

  lc_line_decode u_dec (
    .word_i(word), .hook_s_i(hook_s), .trip_s_i(trip_s), .therm_s_i(therm_s),
    .ctrl_o(ctrl_d), .det_n_o(det_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= RST_CTRL;
      det_q   <= 1'b1;
      relay_q <= RST_WORD[5];
      bad_q   <= RST_CTRL.bad;
    end else begin
      ctrl_q  <= ctrl_d;
      det_q   <= det_d;
      relay_q <= word[5];
      bad_q   <= bad_q | ctrl_d.bad;
    end
  end

  assign sw_o       = ctrl_q.sw;
  assign fb_sw_o    = ctrl_q.fb;
  assign tip_pd_o   = ctrl_q.tip_pd;
  assign ring_pd_o  = ctrl_q.ring_pd;
  assign rev_pol_o  = ctrl_q.rev;
  assign low_ilim_o = ctrl_q.low_ilim;
  assign det_sel_o  = ctrl_q.det_trip;
  assign det_n_o    = det_q;
  assign relay_n_o  = relay_q;
  assign bad_code_o = bad_q;
endmodule

// File: rtl/lc_checker.sv
module lc_checker (
  input logic       clk,
  input logic       rst,
  input logic       cap_en,
  input logic [5:0] word,
  input logic       therm_s,
  input logic [5:0] sw_o,
  input logic [1:0] fb_sw_o,
  input logic       tip_pd_o,
  input logic       ring_pd_o,
  input logic       det_sel_o,
  input logic       det_n_o,
  input logic       relay_n_o,
  input logic       bad_code_o
);
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> $stable(word)); // R1
  AST_RING_CFG: assert property (@(posedge clk) disable iff (rst)
    det_sel_o |-> (sw_o[0] && sw_o[4] && !sw_o[1] && !sw_o[3] && tip_pd_o && ring_pd_o)); // R5
  AST_HIZ_OPEN: assert property (@(posedge clk) disable iff (rst)
    (word[3:0] == 4'b0000) |=> (!sw_o[0] && !sw_o[1] && !sw_o[3] && !sw_o[4] && fb_sw_o == 2'b00)); // R6
  AST_TEST_CLOSE: assert property (@(posedge clk) disable iff (rst)
    !word[4] |=> (sw_o[2] && sw_o[5])); // R7
  AST_RELAY_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (relay_n_o == $past(word[5]))); // R7
  AST_THERM_DET: assert property (@(posedge clk) disable iff (rst)
    therm_s |=> !det_n_o); // R8
  AST_BAD_STICKY: assert property (@(posedge clk) disable iff (rst)
    bad_code_o |=> bad_code_o); // R9
endmodule

bind line_ctrl_top lc_checker u_chk (
  .clk(clk), .rst(rst), .cap_en(cap_en), .word(word), .therm_s(therm_s),
  .sw_o(sw_o), .fb_sw_o(fb_sw_o), .tip_pd_o(tip_pd_o), .ring_pd_o(ring_pd_o),
  .det_sel_o(det_sel_o), .det_n_o(det_n_o), .relay_n_o(relay_n_o),
  .bad_code_o(bad_code_o)
);

// File: tb/line_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module line_ctrl_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_n_i = 1'b1;
  logic [5:0] cmd_i = 6'b0;
  logic       hook_i = 1'b0, trip_i = 1'b0, therm_i = 1'b0;
  logic [5:0] sw_o;
  logic [1:0] fb_sw_o;
  logic       tip_pd_o, ring_pd_o, rev_pol_o, low_ilim_o, det_sel_o;
  logic       det_n_o, relay_n_o, bad_code_o;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  line_ctrl_top dut_i (
    .clk(clk), .rst(rst), .sel_n_i(sel_n_i), .cmd_i(cmd_i),
    .hook_i(hook_i), .trip_i(trip_i), .therm_i(therm_i),
    .sw_o(sw_o), .fb_sw_o(fb_sw_o), .tip_pd_o(tip_pd_o), .ring_pd_o(ring_pd_o),
    .rev_pol_o(rev_pol_o), .low_ilim_o(low_ilim_o), .det_sel_o(det_sel_o),
    .det_n_o(det_n_o), .relay_n_o(relay_n_o), .bad_code_o(bad_code_o)
  );

  function automatic logic [12:0] cfg_now();
    return {sw_o, fb_sw_o, tip_pd_o, ring_pd_o, rev_pol_o, low_ilim_o, det_sel_o};
  endfunction

  // Expected {sw, fb, tip_pd, ring_pd, rev, low, det_sel} from the requirements.
  function automatic logic [12:0] exp_cfg(input logic [5:0] w);
    logic [5:0] sw; logic [1:0] fb; logic tp, rp, rv, lo, ds;
    sw = 0; fb = 0; tp = 1; rp = 1; ds = 0;
    case (w[3:0])
      4'hF, 4'h7, 4'hA, 4'h5, 4'h9, 4'h1: begin sw = 6'b001010; fb = 2'b11; tp = 0; rp = 0; end
      4'hE, 4'h6: begin sw = 6'b001000; fb = 2'b10; rp = 0; end
      4'hD:       begin sw = 6'b001001; fb = 2'b10; rp = 0; end
      4'hC, 4'h4: begin sw = 6'b000010; fb = 2'b01; tp = 0; end
      4'hB, 4'h3: begin sw = 6'b010001; ds = 1; end
      default: ;
    endcase
    rv = (w[3:0] inside {4'h7, 4'h6, 4'h4, 4'h1});
    lo = (w[3:0] inside {4'h9, 4'h1});
    if (!w[4]) sw = sw | 6'b100100;
    return {sw, fb, tp, rp, rv, lo, ds};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [5:0] w);
    @(negedge clk);
    cmd_i = w; sel_n_i = 1'b0;
    repeat (3) @(negedge clk);
    sel_n_i = 1'b1;
    settle(4);
  endtask

  task automatic t_reset();
    chk("R10 cfg", cfg_now(), exp_cfg(6'b000000));
    chk("R10 relay", relay_n_o, 0);
    chk("R10 bad", bad_code_o, 0);
    chk("R10 det", det_n_o, 1);
  endtask

  task automatic t_codes();
    for (int c = 0; c < 16; c++) begin
      if (c == 2) continue;
      send({2'b11, c[3:0]});
      chk("R2-R6 cfg", cfg_now(), exp_cfg({2'b11, c[3:0]}));
      chk("R7 relay off", relay_n_o, 1);
    end
    send(6'b111111);
    chk("R2 talk", cfg_now(), 13'b001010_11_00000);
    send(6'b111001);
    chk("R2 low ilim", low_ilim_o, 1);
    send(6'b110110);
    chk("R3 tip open rev", cfg_now(), 13'b001000_10_10100);
    send(6'b111101);
    chk("R3 tip ground", sw_o, 6'b001001);
    send(6'b111100);
    chk("R4 ring open", cfg_now(), 13'b000010_01_01000);
    send(6'b110011);
    chk("R5 ringing", cfg_now(), 13'b010001_00_11001);
    send(6'b111000);
    chk("R6 hiz", cfg_now(), 13'b000000_00_11000);
  endtask

  task automatic t_hold();
    send(6'b111111);
    @(negedge clk); cmd_i = 6'b001000;
    settle(8);
    chk("R1 steady high", cfg_now(), exp_cfg(6'b111111));
    chk("R1 steady high relay", relay_n_o, 1);
    sel_n_i = 1'b0;
    settle(8);
    chk("R1 falling edge", cfg_now(), exp_cfg(6'b111111));
    cmd_i = 6'b111100;
    settle(8);
    chk("R1 steady low", cfg_now(), exp_cfg(6'b111111));
    sel_n_i = 1'b1;
    settle(4);
    chk("R1 rising edge", cfg_now(), exp_cfg(6'b111100));
  endtask

  task automatic t_overrides();
    send(6'b101111);
    chk("R7 test in closed", sw_o, 6'b101110);
    chk("R7 relay off", relay_n_o, 1);
    send(6'b011011);
    chk("R7 relay on", relay_n_o, 0);
    chk("R7 test open ringing", sw_o, 6'b010001);
    send(6'b001000);
    chk("R7 both in hiz", {sw_o, relay_n_o}, 7'b100100_0);
  endtask

  task automatic t_detect();
    send(6'b111111);
    hook_i = 1'b1; settle(3);
    chk("R11 offhook", det_n_o, 0);
    hook_i = 1'b0; settle(3);
    chk("R11 onhook", det_n_o, 1);
    send(6'b111011);
    hook_i = 1'b1; settle(3);
    chk("R5 hook ignored", det_n_o, 1);
    trip_i = 1'b1; settle(3);
    chk("R5 trip", det_n_o, 0);
    send(6'b111000);
    chk("R6 det high", det_n_o, 1);
    therm_i = 1'b1; settle(3);
    chk("R8 thermal hiz", det_n_o, 0);
    send(6'b111111);
    hook_i = 1'b0; trip_i = 1'b0; settle(3);
    chk("R8 thermal active", det_n_o, 0);
    therm_i = 1'b0; settle(3);
    chk("R8 release", det_n_o, 1);
  endtask

  task automatic t_unassigned();
    chk("R9 clear before", bad_code_o, 0);
    send(6'b110010);
    chk("R9 hiz cfg", cfg_now(), exp_cfg(6'b111000));
    chk("R9 flag", bad_code_o, 1);
    send(6'b111111);
    chk("R9 sticky", bad_code_o, 1);
    chk("R9 next state", cfg_now(), exp_cfg(6'b111111));
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    settle(1);
    t_reset();
    t_codes();
    t_hold();
    t_overrides();
    t_detect();
    t_unassigned();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule